// File: doc/BRIEF.md
# Capture/Compare Timer with Handshake Status Flags

This block is one timer channel. A 16-bit up-counter advances on every clock in which a tick strobe is high. Four general registers, labelled A to D, sit beside it. When the timer is not in PWM mode, each general register works either as a capture register or as a compare register. A capture register latches the counter when its trigger strobe fires. A compare register raises its flag when the ticking counter reaches its value. In PWM mode, register D holds the period and registers A to C hold duty values that raise no flags.

A status register holds one flag for each general register plus an overflow flag. A flag is cleared only by a handshake: software reads the flag as 1, then writes 0 to that bit. Each capture trigger comes with a source tag. A capture fed by another channel's compare match updates the register but leaves the flag alone. Each flag drives an interrupt request, gated by its own enable bit.

Software reaches the block through a single-cycle register bus. Address map: 0 counter, 1 to 4 general registers A to D, 5 mode, 6 status, 7 interrupt enable.

Top module: `cct_timer`

## Requirements
- R1: After synchronous reset, the following are all zero: the counter, every general register, mode, status, interrupt enable, read data and every interrupt request.
- R2: The counter adds one on each clock with `cnt_tick` high and holds otherwise. A bus write to address 0 loads it, and the load takes priority over counting.
- R3: Status bit 4 (overflow) sets when a tick steps the counter from 0xFFFF to 0x0000.
- R4: With PWM off and mode bit i equal to 0, status bit i sets when a tick occurs while the counter equals general register i. Status bits 0 to 3 belong to registers A to D.
- R5: With PWM off and mode bit i equal to 1, a `cap_trig[i]` strobe copies the counter into register i. If `cap_from_chan[i]` is 0, status bit i also sets.
- R6: A capture strobe with `cap_from_chan[i]` equal to 1 loads register i but does not set status bit i.
- R7: A write of 0 to a status bit clears it only if the last status read, with no status write or set event since, returned that bit as 1. A zero write without such a read leaves the flag set.
- R8: Writing 1 to a status bit has no effect. A set event in the same cycle as a clearing write keeps the flag set. A set event between the read and the zero write also keeps it set.
- R9: Mode bit 4 selects PWM. In PWM mode, status bits 0 to 2 never set, capture strobes are ignored, and only register D raises its flag, on a tick at counter equality.
- R10: In PWM mode, a tick while the counter equals register D makes the counter 0 on the next clock instead of adding one.
- R11: `irq[k]` equals status bit k ANDed with interrupt-enable bit k. Bits 0 to 3 belong to registers A to D and bit 4 to overflow. `irq` updates on the same clock as the flag.
- R12: A read presented with `bus_rd` appears on `bus_rdata` after the next clock edge. Narrow registers read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count enable strobe |
| cap_trig | input | 4 | Capture strobe per general register |
| cap_from_chan | input | 4 | Capture source tag: 1 = another channel's compare match |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 5 | Gated interrupt request per flag |

## Verification
The hardest states to reach are those where a hardware set event meets the clearing handshake. One case is a set event in the same clock as the zero write. The other is a set event landing between the read and the write. The stimulus reaches the first by driving a capture strobe together with the status write on the same clock edge. It reaches the second by pulsing a capture after the read and before the write. In both cases a follow-up read must still show the flag. PWM wrap and overflow are reached by preloading the counter over the bus just short of the boundary and then issuing an exact number of ticks.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    ROLE_COMPARE,
    ROLE_CAPTURE,
    ROLE_PWM_DUTY,
    ROLE_PWM_PERIOD
  } gr_role_e;

  localparam int ADR_COUNT = 0;

  function automatic int adr_gr(input int idx);
    return 1 + idx;
  endfunction

  function automatic int adr_mode(input int n_gr);
    return n_gr + 1;
  endfunction

  function automatic int adr_stat(input int n_gr);
    return n_gr + 2;
  endfunction

  function automatic int adr_ien(input int n_gr);
    return n_gr + 3;
  endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             period_hit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);

  logic [CNT_W-1:0] cnt_d;

  // a rollover only counts when the step is a genuine count, not a load
  assign ovf_evt = tick && (&cnt_q) && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (period_hit) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cct_gr_channel.sv
module cct_gr_channel
  import cct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  gr_role_e         role,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cnt_tick,
  input  logic             cap_trig,
  input  logic             cap_from_chan,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] gr_q,
  output logic             flag_set
);

  logic cap_evt;
  logic match;

  assign cap_evt = (role == ROLE_CAPTURE) && cap_trig;
  assign match   = cnt_tick && (cnt_q == gr_q);

  always_comb begin
    unique case (role)
      ROLE_CAPTURE:    flag_set = cap_evt && !cap_from_chan;
      ROLE_COMPARE:    flag_set = match;
      ROLE_PWM_PERIOD: flag_set = match;
      default:         flag_set = 1'b0;
    endcase
  end

  // a capture wins over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          gr_q <= '0;
    else if (cap_evt) gr_q <= cnt_q;
    else if (wr_en)   gr_q <= wdata;
  end

endmodule

// File: rtl/cct_flag_bank.sv
module cct_flag_bank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_evt,
  input  logic          rd_stat,
  input  logic          wr_stat,
  input  logic          wr_ien,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flag_q,
  output logic [NF-1:0] ien_q,
  output logic [NF-1:0] irq_q
);

  logic [NF-1:0] arm_q;
  logic [NF-1:0] flag_d;
  logic [NF-1:0] arm_d;
  logic [NF-1:0] ien_d;

  assign ien_d = wr_ien ? wdata : ien_q;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    for (int k = 0; k < NF; k++) begin
      if (set_evt[k]) begin
        flag_d[k] = 1'b1;
        arm_d[k]  = 1'b0;
      end else if (wr_stat) begin
        if (arm_q[k] && !wdata[k]) flag_d[k] = 1'b0;
        arm_d[k] = 1'b0;
      end else if (rd_stat) begin
        arm_d[k] = flag_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      arm_q  <= '0;
      ien_q  <= '0;
      irq_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      ien_q  <= ien_d;
      irq_q  <= flag_d & ien_d;
    end
  end

endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic [NUM_GR-1:0] cap_trig,
  input  logic [NUM_GR-1:0] cap_from_chan,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_GR:0]   irq
);

  localparam int NF       = NUM_GR + 1;
  localparam int MODE_W   = NUM_GR + 1;
  localparam int ADR_MODE = adr_mode(NUM_GR);
  localparam int ADR_STAT = adr_stat(NUM_GR);
  localparam int ADR_IEN  = adr_ien(NUM_GR);

  logic [CNT_W-1:0]              cnt_q;
  logic                          ovf_evt;
  logic                          cnt_load;
  logic                          period_hit;
  logic [NUM_GR-1:0][CNT_W-1:0]  gr_q;
  logic [NUM_GR-1:0]             gr_flag_set;
  logic [MODE_W-1:0]             mode_q;
  logic                          pwm;
  logic [NUM_GR-1:0]             cap_sel;
  logic [NF-1:0]                 flag_q;
  logic [NF-1:0]                 ien_q;
  logic                          stat_rd;
  logic                          stat_wr;
  logic                          ien_wr;
  logic [CNT_W-1:0]              rd_mux;
  logic [CNT_W-1:0]              rdata_q;

  assign pwm      = mode_q[NUM_GR];
  assign cap_sel  = mode_q[NUM_GR-1:0];
  assign cnt_load = bus_wr && (bus_addr == ADDR_W'(ADR_COUNT));
  assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign stat_rd  = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));
  assign ien_wr   = bus_wr && (bus_addr == ADDR_W'(ADR_IEN));

  // in PWM mode the last register is the period and is the only one flagging
  assign period_hit = pwm && gr_flag_set[NUM_GR-1];

  cct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .tick       (cnt_tick),
    .load       (cnt_load),
    .load_val   (bus_wdata),
    .period_hit (period_hit),
    .cnt_q      (cnt_q),
    .ovf_evt    (ovf_evt)
  );

  for (genvar i = 0; i < NUM_GR; i++) begin : g_ch
    gr_role_e role;
    logic     gr_wr;

    if (i == NUM_GR - 1) begin : g_period
      assign role = pwm ? ROLE_PWM_PERIOD
                        : (cap_sel[i] ? ROLE_CAPTURE : ROLE_COMPARE);
    end else begin : g_duty
      assign role = pwm ? ROLE_PWM_DUTY
                        : (cap_sel[i] ? ROLE_CAPTURE : ROLE_COMPARE);
    end

    assign gr_wr = bus_wr && (bus_addr == ADDR_W'(adr_gr(i)));

    cct_gr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk           (clk),
      .rst           (rst),
      .role          (role),
      .cnt_q         (cnt_q),
      .cnt_tick      (cnt_tick),
      .cap_trig      (cap_trig[i]),
      .cap_from_chan (cap_from_chan[i]),
      .wr_en         (gr_wr),
      .wdata         (bus_wdata),
      .gr_q          (gr_q[i]),
      .flag_set      (gr_flag_set[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= '0;
    else if (bus_wr && (bus_addr == ADDR_W'(ADR_MODE)))
      mode_q <= bus_wdata[MODE_W-1:0];
  end

  cct_flag_bank #(.NF(NF)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_evt ({ovf_evt, gr_flag_set}),
    .rd_stat (stat_rd),
    .wr_stat (stat_wr),
    .wr_ien  (ien_wr),
    .wdata   (bus_wdata[NF-1:0]),
    .flag_q  (flag_q),
    .ien_q   (ien_q),
    .irq_q   (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADR_COUNT)) rd_mux = cnt_q;
    for (int i = 0; i < NUM_GR; i++) begin
      if (bus_addr == ADDR_W'(adr_gr(i))) rd_mux = gr_q[i];
    end
    if (bus_addr == ADDR_W'(ADR_MODE)) rd_mux = CNT_W'(mode_q);
    if (bus_addr == ADDR_W'(ADR_STAT)) rd_mux = CNT_W'(flag_q);
    if (bus_addr == ADDR_W'(ADR_IEN))  rd_mux = CNT_W'(ien_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 4,
  parameter int ADDR_W = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         cnt_tick,
  input logic [NUM_GR-1:0]            cap_trig,
  input logic [NUM_GR-1:0]            cap_from_chan,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         bus_wr,
  input logic [CNT_W-1:0]             bus_wdata,
  input logic [NUM_GR:0]              irq,
  input logic [CNT_W-1:0]             cnt_q,
  input logic [NUM_GR-1:0][CNT_W-1:0] gr_q,
  input logic [NUM_GR:0]              mode_q,
  input logic [NUM_GR:0]              flag_q,
  input logic [NUM_GR:0]              ien_q
);

  logic pwm;
  logic cnt_wr;
  logic stat_wr;

  assign pwm     = mode_q[NUM_GR];
  assign cnt_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_COUNT));
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(adr_stat(NUM_GR)));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_q == '0 && irq == '0 && cnt_q == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !cnt_wr && !(pwm && cnt_q == gr_q[NUM_GR-1]))
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_tick && !cnt_wr) |=> $stable(cnt_q));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && (&cnt_q) && !cnt_wr) |=> flag_q[NUM_GR]);

  p_pwm_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    pwm |=> ((flag_q[NUM_GR-2:0] & ~$past(flag_q[NUM_GR-2:0])) == '0));

  p_pwm_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (pwm && cnt_tick && !cnt_wr && cnt_q == gr_q[NUM_GR-1]) |=> (cnt_q == '0));

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q & ien_q));

  for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
    p_cap_load_r5: assert property (@(posedge clk) disable iff (rst)
      (!pwm && mode_q[i] && cap_trig[i]) |=> (gr_q[i] == $past(cnt_q)));

    p_chan_noflag_r6: assert property (@(posedge clk) disable iff (rst)
      (!pwm && mode_q[i] && cap_trig[i] && cap_from_chan[i] && !flag_q[i])
        |=> !flag_q[i]);
  end

  for (genvar k = 0; k <= NUM_GR; k++) begin : g_fl
    p_zero_write_clear_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[k]) |-> $past(stat_wr && !bus_wdata[k]));
  end

endmodule

bind cct_timer cct_timer_chk #(
  .CNT_W  (CNT_W),
  .NUM_GR (NUM_GR),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cnt_tick      (cnt_tick),
  .cap_trig      (cap_trig),
  .cap_from_chan (cap_from_chan),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .irq           (irq),
  .cnt_q         (cnt_q),
  .gr_q          (gr_q),
  .mode_q        (mode_q),
  .flag_q        (flag_q),
  .ien_q         (ien_q)
);

// File: tb/cct_timer_tb.sv
module cct_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CNT = 3'd0, A_GRA = 3'd1, A_GRB = 3'd2,
                         A_GRC = 3'd3, A_GRD = 3'd4, A_MODE = 3'd5,
                         A_STAT = 3'd6, A_IEN = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_tick = 1'b0;
  logic [3:0]  cap_trig = '0;
  logic [3:0]  cap_from_chan = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  irq;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cct_timer u_dut (
    .clk           (clk),
    .rst           (rst),
    .cnt_tick      (cnt_tick),
    .cap_trig      (cap_trig),
    .cap_from_chan (cap_from_chan),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq           (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic pulse_cap(input int idx, input logic from_chan);
    @(negedge clk);
    cap_trig[idx] = 1'b1; cap_from_chan[idx] = from_chan;
    @(negedge clk);
    cap_trig = '0; cap_from_chan = '0;
  endtask

  task automatic expect_reg(input string req, input string what,
                            input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    bus_read(a, v);
    check(req, what, v, exp);
  endtask

  task automatic t_reset;
    check("R1", "irq after reset", {11'd0, irq}, 16'h0000);
    check("R1", "rdata after reset", bus_rdata, 16'h0000);
    expect_reg("R1", "counter", A_CNT, 16'h0000);
    expect_reg("R1", "status", A_STAT, 16'h0000);
    expect_reg("R1", "ien", A_IEN, 16'h0000);
    expect_reg("R1", "mode", A_MODE, 16'h0000);
    expect_reg("R1", "grA", A_GRA, 16'h0000);
    bus_write(A_GRA, 16'h0100);
    bus_write(A_GRB, 16'h0200);
    bus_write(A_GRC, 16'h0300);
    bus_write(A_GRD, 16'h0400);
  endtask

  task automatic t_count;
    bus_write(A_CNT, 16'h0050);
    expect_reg("R2", "counter load", A_CNT, 16'h0050);
    tick_n(5);
    expect_reg("R2", "counter after 5 ticks", A_CNT, 16'h0055);
    expect_reg("R12", "grB readback", A_GRB, 16'h0200);
    expect_reg("R4", "no stray match", A_STAT, 16'h0000);
  endtask

  task automatic t_overflow_handshake;
    bus_write(A_CNT, 16'hFFFE);
    tick_n(2);
    expect_reg("R3", "counter wrapped", A_CNT, 16'h0000);
    expect_reg("R3", "overflow flag", A_STAT, 16'h0010);
    bus_write(A_STAT, 16'h001F);
    bus_write(A_STAT, 16'h0000);
    expect_reg("R7", "unarmed zero write / ones write", A_STAT, 16'h0010);
    bus_write(A_STAT, 16'h0000);
    expect_reg("R7", "read then zero write clears", A_STAT, 16'h0000);
  endtask

  task automatic t_compare;
    bus_write(A_MODE, 16'h0000);
    bus_write(A_GRA, 16'h0020);
    bus_write(A_CNT, 16'h001E);
    tick_n(3);
    expect_reg("R4", "compare flag A", A_STAT, 16'h0001);
    check("R11", "irq masked", {11'd0, irq}, 16'h0000);
    bus_write(A_STAT, 16'h0000);
    expect_reg("R4", "compare flag cleared", A_STAT, 16'h0000);
  endtask

  task automatic t_capture;
    bus_write(A_MODE, 16'h0001);
    bus_write(A_CNT, 16'h1234);
    pulse_cap(0, 1'b0);
    expect_reg("R5", "captured value A", A_GRA, 16'h1234);
    expect_reg("R5", "capture flag A", A_STAT, 16'h0001);
    bus_write(A_STAT, 16'h0000);
    bus_write(A_MODE, 16'h0003);
    bus_write(A_CNT, 16'h0777);
    pulse_cap(1, 1'b1);
    expect_reg("R6", "chained capture value B", A_GRB, 16'h0777);
    expect_reg("R6", "chained capture no flag", A_STAT, 16'h0000);
  endtask

  task automatic t_set_wins;
    bus_write(A_MODE, 16'h0001);
    pulse_cap(0, 1'b0);
    expect_reg("R8", "flag set", A_STAT, 16'h0001);
    pulse_cap(0, 1'b0);
    bus_write(A_STAT, 16'h0000);
    expect_reg("R8", "event between read and write", A_STAT, 16'h0001);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 16'h0000;
    cap_trig[0] = 1'b1; cap_from_chan[0] = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; cap_trig = '0;
    expect_reg("R8", "set same cycle as clear", A_STAT, 16'h0001);
    bus_write(A_STAT, 16'h0000);
    expect_reg("R8", "final clear", A_STAT, 16'h0000);
  endtask

  task automatic t_pwm;
    bus_write(A_MODE, 16'h0011);
    bus_write(A_GRA, 16'h0002);
    bus_write(A_GRB, 16'h0003);
    bus_write(A_GRC, 16'h0004);
    bus_write(A_GRD, 16'h000A);
    bus_write(A_CNT, 16'h0000);
    tick_n(11);
    expect_reg("R10", "counter cleared at period", A_CNT, 16'h0000);
    tick_n(3);
    expect_reg("R10", "counter restarts", A_CNT, 16'h0003);
    expect_reg("R9", "only period flag", A_STAT, 16'h0008);
    pulse_cap(0, 1'b0);
    expect_reg("R9", "capture ignored value", A_GRA, 16'h0002);
    expect_reg("R9", "capture ignored flag", A_STAT, 16'h0008);
    bus_write(A_STAT, 16'h0000);
    expect_reg("R9", "pwm flag cleared", A_STAT, 16'h0000);
  endtask

  task automatic t_irq;
    bus_write(A_MODE, 16'h0000);
    bus_write(A_IEN, 16'h0011);
    bus_write(A_GRA, 16'h0040);
    bus_write(A_GRB, 16'h0001);
    bus_write(A_CNT, 16'h003F);
    tick_n(2);
    check("R11", "irq from flag A", {11'd0, irq}, 16'h0001);
    bus_write(A_CNT, 16'hFFFF);
    tick_n(1);
    check("R11", "irq from overflow", {11'd0, irq}, 16'h0011);
    tick_n(2);
    check("R11", "flag B masked", {11'd0, irq}, 16'h0011);
    expect_reg("R11", "status with B", A_STAT, 16'h0013);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_overflow_handshake();
    t_compare();
    t_capture();
    t_set_wins();
    t_pwm();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule